// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the interrupt flags and interrupt enables of a real-time-clock style device and produces its interrupt request. Three event sources (periodic tick, alarm match, update-ended) each deliver a one-cycle pulse. Each pulse sets its own flag in a status register. A control register holds one enable per source and a square-wave output enable. The block is a register slice that sits beside the timekeeping logic, on a simple strobe-and-address register bus.

Whenever a flag and its enable are both set, the block pulls the interrupt request line low. It does this through an output-enable signal, in the manner of an open-drain pin, and never drives the line high. Reading the status register returns the flags together with a summary bit, then clears the flags. This releases the request. A synchronous active-low reset clears all enables and flags.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the enables, the square-wave enable, all flags and `rdata` are cleared. After that edge, `irq_oe` is 0, and reads of the control register and the status register return 0x00.
- R2: The control register is at address 1. Bit 6 enables the periodic source, bit 5 the alarm source, bit 4 the update-ended source, and bit 3 is the square-wave enable, also presented on `sqw_en`. A write stores these four bits. Bits 7 and 2..0 read as zero.
- R3: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets status bit 6, 5 or 4 respectively at that clock edge, whether or not its enable is set.
- R4: `irq_oe` is 1 exactly when some flag is set and its enable bit is set. Clearing the enable releases the request without clearing the flag.
- R5: Status bit 7 reads as the OR over the three sources of flag AND enable.
- R6: The status register is at address 2. A read returns the flags as they were before the read, then clears them, so `irq_oe` is 0 in the following cycle if no event arrived.
- R7: An event arriving in the same cycle as a clearing status read is not returned by that read. Its flag stays set afterwards.
- R8: Status bits 3..0 always read as zero. Writes to the status address change no flag.
- R9: Flags persist across cycles without events, and across reads of other addresses, until the status register is read.
- R10: `rdata` is registered. It takes the addressed value at the edge where `rd_en` is high and holds it otherwise. Unmapped addresses (0 and 3) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| irq_oe | output | 1 | 1 = pull the interrupt line low, 0 = release |
| sqw_en | output | 1 | Square-wave output enable bit |

## Verification
The hardest case to reach is an event pulse that lands in the exact cycle of a clearing status read. The read must not report that event, yet the event must survive the clear. The bench aligns a status read and a periodic pulse on the same strobe cycle, with an older alarm flag already pending. It then checks both the returned byte and a second read. Every combination of the three enables and the three event pulses is also swept, and the request, the summary bit and the release after the read are checked for each combination.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the RTC interrupt flag controller.
// Assumes source index 0 = update-ended, 1 = alarm, 2 = periodic.
package rtc_irq_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_SRC    = 3;
    localparam int SRC_LSB    = 4;   // bit of source 0 in both registers
    localparam int MASTER_BIT = 7;   // summary bit in the status register
    localparam int SQW_BIT    = 3;   // square-wave enable in the control register
    localparam logic [DATA_W-1:0] CTRL_MASK =
        DATA_W'(((1 << NUM_SRC) - 1) << SRC_LSB) | DATA_W'(1 << SQW_BIT);
endpackage

// File: rtl/rtc_irq_ctrl_reg.sv
// Control register: per-source interrupt enables and the square-wave enable.
// Assumes the write strobe is already decoded. Unimplemented bits stay zero.
module rtc_irq_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);
    // Purpose: store the implemented control bits, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wdata & CTRL_MASK;
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q == ($past(wdata) & CTRL_MASK)));
    assert_ctrl_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0));
endmodule

// File: rtl/rtc_irq_flags.sv
// Event flags: one sticky flag per source, set by its pulse, cleared by a status read.
// Assumes clr is a one-cycle strobe. A same-cycle event wins over the clear.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flag_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Purpose: keep the flag sticky, drop it on clear unless a new event arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else
                flag_q[i] <= (flag_q[i] & ~clr) | evt[i];
        end

        assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag_q[i]);
        assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr) |=> flag_q[i]);
        assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && evt[i]) |=> flag_q[i]);
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top level: address decode, registered read port, summary bit and interrupt request.
// Assumes single-cycle rd_en/wr_en strobes and one-cycle event pulses.
// irq_oe models an open-drain output: 1 pulls the line low, 0 releases it.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int                ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    output logic              irq_oe,
    output logic              sqw_en
);
    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] src_en;
    logic [DATA_W-1:0]  status_word;
    logic               pending_any;
    logic               rd_stat;
    logic               wr_ctrl;

    assign evt     = {evt_periodic, evt_alarm, evt_update};
    assign wr_ctrl = wr_en && (addr == CTRL_ADDR);
    assign rd_stat = rd_en && (addr == STAT_ADDR);
    assign src_en  = ctrl_q[SRC_LSB +: NUM_SRC];
    assign sqw_en  = ctrl_q[SQW_BIT];

    rtc_irq_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q)
    );

    rtc_irq_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (rd_stat),
        .flag_q (flag_q)
    );

    // Purpose: summary of enabled pending sources, drives the request line.
    always_comb begin
        pending_any = |(flag_q & src_en);
        irq_oe      = pending_any;
    end

    // Purpose: assemble the status byte; the low nibble is fixed at zero.
    always_comb begin
        status_word                       = '0;
        status_word[SRC_LSB +: NUM_SRC]   = flag_q;
        status_word[MASTER_BIT]           = pending_any;
    end

    // Purpose: capture read data on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            if (addr == CTRL_ADDR)
                rdata <= ctrl_q;
            else if (addr == STAT_ADDR)
                rdata <= status_word;
            else
                rdata <= '0;
        end
    end

    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (evt == '0)) |=> !irq_oe);
    assert_low_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rdata[3:0] == 4'h0));
    assert_master_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rdata[MASTER_BIT] == $past(irq_oe)));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_oe && (rdata == '0)));
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       irq_oe;
    logic       sqw_en;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .wr_en (wr_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .evt_periodic (evt_periodic), .evt_alarm (evt_alarm), .evt_update (evt_update),
        .irq_oe (irq_oe), .sqw_en (sqw_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // events: bit2 periodic, bit1 alarm, bit0 update
    task automatic rd(input logic [1:0] a, input logic [2:0] ev, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        {evt_periodic, evt_alarm, evt_update} = ev;
        @(negedge clk); rd_en = 1'b0; {evt_periodic, evt_alarm, evt_update} = 3'b000;
        d = rdata;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk); {evt_periodic, evt_alarm, evt_update} = ev;
        @(negedge clk); {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq after reset", {7'd0, irq_oe}, 8'h00);
        check("R1 rdata after reset", rdata, 8'h00);
        rd(2'd1, 3'b000, d); check("R1 ctrl after reset", d, 8'h00);
        rd(2'd2, 3'b000, d); check("R1 status after reset", d, 8'h00);

        // R2 control readback with all data patterns
        for (int w = 0; w < 256; w++) begin
            wr(2'd1, 8'(w));
            rd(2'd1, 3'b000, d);
            check("R2 ctrl readback", d, 8'(w) & 8'h78);
            check("R2 sqw_en", {7'd0, sqw_en}, {7'd0, 1'(w >> 3)});
        end

        // R3 R4 R5 R6 exhaustive enable x event sweep
        for (int en = 0; en < 8; en++) begin
            for (int ev = 0; ev < 8; ev++) begin
                wr(2'd1, 8'((en << 4) | ((ev & 1) << 3)));
                rd(2'd2, 3'b000, d);
                pulse(3'(ev));
                check("R4 irq level", {7'd0, irq_oe}, {7'd0, 1'((en & ev) != 0)});
                rd(2'd2, 3'b000, d);
                check("R3 R5 status byte", d, 8'((((en & ev) != 0) << 7) | (ev << 4)));
                check("R6 irq released", {7'd0, irq_oe}, 8'h00);
                rd(2'd2, 3'b000, d);
                check("R6 flags cleared", d, 8'h00);
            end
        end

        // R7 event in the same cycle as a clearing read
        wr(2'd1, 8'h70);
        pulse(3'b010);
        rd(2'd2, 3'b100, d);
        check("R7 read excludes same-cycle event", d, 8'hA0);
        check("R7 irq still held", {7'd0, irq_oe}, 8'h01);
        rd(2'd2, 3'b000, d);
        check("R7 pending event kept", d, 8'hC0);

        // R9 flags persist across idle cycles and control reads
        pulse(3'b001);
        repeat (5) @(negedge clk);
        rd(2'd1, 3'b000, d);
        check("R9 irq held after ctrl read", {7'd0, irq_oe}, 8'h01);
        // R8 write to status ignored
        wr(2'd2, 8'hFF);
        rd(2'd2, 3'b000, d);
        check("R8 R9 status after write", d, 8'h90);

        // R4 disabling the enable releases, flag stays
        pulse(3'b100);
        wr(2'd1, 8'h00);
        check("R4 irq released by enable", {7'd0, irq_oe}, 8'h00);
        rd(2'd2, 3'b000, d);
        check("R4 flag kept, master low", d, 8'h40);

        // R10 hold and unmapped addresses
        wr(2'd1, 8'h58);
        rd(2'd1, 3'b000, held);
        repeat (4) @(negedge clk);
        check("R10 rdata holds", rdata, held);
        rd(2'd3, 3'b000, d); check("R10 unmapped 3", d, 8'h00);
        rd(2'd1, 3'b000, d);
        rd(2'd0, 3'b000, d); check("R10 unmapped 0", d, 8'h00);

        // R1 reset mid-run
        wr(2'd1, 8'h78);
        pulse(3'b111);
        rd(2'd1, 3'b000, d);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq released by reset", {7'd0, irq_oe}, 8'h00);
        check("R1 rdata cleared", rdata, 8'h00);
        check("R1 sqw cleared", {7'd0, sqw_en}, 8'h00);
        rd(2'd1, 3'b000, d); check("R1 ctrl cleared", d, 8'h00);
        rd(2'd2, 3'b000, d); check("R1 flags cleared", d, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule